// File: doc/BRIEF.md
# Dual-Sample Serial Frame Link

This block moves converter samples across a single serial wire. It runs on a bit clock that is 48 times the symbol rate. Every symbol period becomes one 48-slot frame, and a symbol strobe pins where each frame starts. Each frame carries two 14-bit two's-complement samples: a primary sample taken for the symbol and a second, independent conversion from the same period. Each sample goes into a 16-bit word. The two low bits of the word are forced to zero, and eight filler bits driven high follow the word. The transmit side launches each bit on the falling edge of the bit clock, so the far end can capture it on the rising edge.

The receive side tracks the same strobe and rebuilds both words. It flags any frame whose fixed pad or filler bits are wrong, and it reports when a whole frame has passed without a strobe. The transmitter holds the latest sample offered on each channel and only puts it on the wire at the start of a frame. The block has no notion of absolute rate, so it works at any symbol rate as long as the bit clock keeps its 48:1 ratio.

Top module: `dual_sample_frame_link`

## Requirements
- R1: Within a frame, the slots carry, in order: slots 0–13 the primary sample MSB first, slots 14–15 low, slots 16–23 high, slots 24–37 the secondary sample MSB first, slots 38–39 low, slots 40–47 high.
- R2: `ser_o` changes only on falling edges of `clk_i`. Slot 0 is driven at the first falling edge on which `sym_strobe_i` is high.
- R3: A sample offered with its valid flag is held. It is sent in the next frame that starts after it was offered. If it arrives mid-frame, the frame in progress is not altered.
- R4: With no strobe, the transmitter wraps after slot 47 and sends a new frame built from the held samples.
- R5: The receiver captures `ser_i` on rising edges. After the edge that captures slot 15, it presents the primary sample (word bits 15..2) on `rx_pri_o` with a one-cycle `rx_pri_valid_o` pulse.
- R6: After the edge that captures slot 39, the receiver presents the secondary sample on `rx_sec_o` with a one-cycle `rx_sec_valid_o` pulse. The two valid pulses never coincide.
- R7: Once a strobe has been seen, a captured pad bit that is 1 or a captured filler bit that is 0 raises `rx_err_o` for one cycle, after the edge that captured it.
- R8: Once locked, if slot 47 passes with no strobe, the receive counter wraps to slot 0 and sets the sticky `rx_align_lost_o`. The next strobe clears it.
- R9: During reset, `ser_o` is high and all receive flags and valid pulses are low.
- R10: A strobe arriving mid-frame restarts both the transmitter and the receiver at slot 0, with no error or alignment-loss indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, 48x symbol rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_strobe_i | input | 1 | Symbol strobe, marks slot 0 |
| pri_sample_i | input | 14 | Primary sample, two's complement |
| pri_valid_i | input | 1 | Primary sample valid |
| sec_sample_i | input | 14 | Secondary sample, two's complement |
| sec_valid_i | input | 1 | Secondary sample valid |
| ser_o | output | 1 | Serial frame out, launched on falling edge |
| ser_i | input | 1 | Serial frame in, captured on rising edge |
| rx_pri_o | output | 14 | Recovered primary sample |
| rx_pri_valid_o | output | 1 | One-cycle pulse for rx_pri_o |
| rx_sec_o | output | 14 | Recovered secondary sample |
| rx_sec_valid_o | output | 1 | One-cycle pulse for rx_sec_o |
| rx_err_o | output | 1 | Pad or filler bit mismatch pulse |
| rx_align_lost_o | output | 1 | Sticky: a frame passed with no strobe |

## Verification
The assertions check on every cycle the properties that need no context. The slot counters must return to 0 after a strobe. The transmitted pad and filler slots must hold their fixed levels. Each valid pulse must line up with its slot and last one cycle, the two pulses must never overlap, and the alignment-loss flag must stay set until a strobe clears it. Other behaviours need chosen stimulus and only the bench's scenarios show them. These are: the exact bit order of both samples, including full-scale corners; the deferral of a sample that arrives mid-frame; frame repetition while free running; error pulses caused by bits flipped on the loopback; and a mid-frame strobe restart.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [1:0] {SK_DATA, SK_PAD, SK_FILL} slot_kind_e;

  // Classify a slot within a frame of two equal halves.
  function automatic slot_kind_e kind_of(int slot, int sample_w, int pad_w, int fill_w);
    int half;
    int pos;
    half = sample_w + pad_w + fill_w;
    pos  = slot % half;
    if (pos < sample_w) return SK_DATA;
    else if (pos < sample_w + pad_w) return SK_PAD;
    else return SK_FILL;
  endfunction
endpackage

// File: rtl/sfl_slot_counter.sv
module sfl_slot_counter #(
  parameter int FRAME_W    = 48,
  parameter int SLOT_W     = 6,
  parameter int RESET_SLOT = 47
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] slot_nxt_o,
  output logic              start_o,
  output logic              wrap_o
);
  logic [SLOT_W-1:0] slot_q;
  logic              last;

  assign last       = (slot_q == SLOT_W'(FRAME_W - 1));
  assign start_o    = sync_i | last;
  assign wrap_o     = last & ~sync_i;
  assign slot_nxt_o = start_o ? '0 : slot_q + SLOT_W'(1);
  assign slot_o     = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= SLOT_W'(RESET_SLOT);
    else         slot_q <= slot_nxt_o;
  end

  assert_sync_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (slot_q == '0));
  assert_slot_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q < SLOT_W'(FRAME_W));
endmodule

// File: rtl/sfl_serializer.sv
module sfl_serializer
  import sfl_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int PAD_W    = 2,
  parameter int FILL_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_i,
  input  logic [SAMPLE_W-1:0] pri_i,
  input  logic                pri_valid_i,
  input  logic [SAMPLE_W-1:0] sec_i,
  input  logic                sec_valid_i,
  output logic                ser_o
);
  localparam int HALF_W  = SAMPLE_W + PAD_W + FILL_W;
  localparam int FRAME_W = 2 * HALF_W;
  localparam int SLOT_W  = $clog2(FRAME_W);

  logic [SAMPLE_W-1:0] pri_hold, sec_hold, pri_nxt, sec_nxt;
  logic [FRAME_W-1:0]  shreg, frame;
  logic [SLOT_W-1:0]   slot, slot_nxt;
  logic                start, wrap;

  sfl_slot_counter #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W), .RESET_SLOT(FRAME_W - 1)) u_cnt (
    .clk_i, .rst_ni, .sync_i,
    .slot_o(slot), .slot_nxt_o(slot_nxt), .start_o(start), .wrap_o(wrap)
  );

  assign pri_nxt = pri_valid_i ? pri_i : pri_hold;
  assign sec_nxt = sec_valid_i ? sec_i : sec_hold;
  assign frame   = {pri_nxt, {PAD_W{1'b0}}, {FILL_W{1'b1}},
                    sec_nxt, {PAD_W{1'b0}}, {FILL_W{1'b1}}};
  assign ser_o   = shreg[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_hold <= '0;
      sec_hold <= '0;
      shreg    <= '1;
    end else begin
      pri_hold <= pri_nxt;
      sec_hold <= sec_nxt;
      if (start) shreg <= frame;
      else       shreg <= {shreg[FRAME_W-2:0], 1'b1};
    end
  end

  assert_tx_pad_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_of(int'(slot), SAMPLE_W, PAD_W, FILL_W) == SK_PAD) |-> !ser_o);
  assert_tx_fill_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_of(int'(slot), SAMPLE_W, PAD_W, FILL_W) == SK_FILL) |-> ser_o);
endmodule

// File: rtl/sfl_deserializer.sv
module sfl_deserializer
  import sfl_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int PAD_W    = 2,
  parameter int FILL_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_i,
  input  logic                ser_i,
  output logic [SAMPLE_W-1:0] pri_o,
  output logic                pri_valid_o,
  output logic [SAMPLE_W-1:0] sec_o,
  output logic                sec_valid_o,
  output logic                err_o,
  output logic                lost_o
);
  localparam int WORD_W  = SAMPLE_W + PAD_W;
  localparam int HALF_W  = WORD_W + FILL_W;
  localparam int FRAME_W = 2 * HALF_W;
  localparam int SLOT_W  = $clog2(FRAME_W);

  logic [WORD_W-1:0]  sh, word;
  logic [SLOT_W-1:0]  slot, slot_nxt;
  logic               start, wrap, locked_q, live, pri_end, sec_end, bad;
  slot_kind_e         kind;

  sfl_slot_counter #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W), .RESET_SLOT(FRAME_W - 1)) u_cnt (
    .clk_i, .rst_ni, .sync_i,
    .slot_o(slot), .slot_nxt_o(slot_nxt), .start_o(start), .wrap_o(wrap)
  );

  assign word    = {sh[WORD_W-2:0], ser_i};
  assign live    = locked_q | sync_i;
  assign pri_end = (slot_nxt == SLOT_W'(WORD_W - 1));
  assign sec_end = (slot_nxt == SLOT_W'(HALF_W + WORD_W - 1));
  assign kind    = kind_of(int'(slot_nxt), SAMPLE_W, PAD_W, FILL_W);
  assign bad     = ((kind == SK_PAD) & ser_i) | ((kind == SK_FILL) & ~ser_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh          <= '0;
      locked_q    <= 1'b0;
      pri_o       <= '0;
      sec_o       <= '0;
      pri_valid_o <= 1'b0;
      sec_valid_o <= 1'b0;
      err_o       <= 1'b0;
      lost_o      <= 1'b0;
    end else begin
      sh          <= word;
      locked_q    <= live;
      pri_valid_o <= live & pri_end;
      sec_valid_o <= live & sec_end;
      err_o       <= live & bad;
      if (live & pri_end) pri_o <= word[WORD_W-1:PAD_W];
      if (live & sec_end) sec_o <= word[WORD_W-1:PAD_W];
      if (sync_i)                lost_o <= 1'b0;
      else if (locked_q & wrap)  lost_o <= 1'b1;
    end
  end

  assert_pri_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_valid_o |-> (slot == SLOT_W'(WORD_W - 1)));
  assert_pri_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_valid_o |=> !pri_valid_o);
  assert_sec_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_valid_o |-> (slot == SLOT_W'(HALF_W + WORD_W - 1)));
  assert_no_overlap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pri_valid_o && sec_valid_o));
  assert_lost_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !lost_o);
  assert_lost_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && !sync_i) |=> lost_o);
endmodule

// File: rtl/dual_sample_frame_link.sv
module dual_sample_frame_link #(
  parameter int SAMPLE_W = 14,
  parameter int PAD_W    = 2,
  parameter int FILL_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sym_strobe_i,
  input  logic [SAMPLE_W-1:0] pri_sample_i,
  input  logic                pri_valid_i,
  input  logic [SAMPLE_W-1:0] sec_sample_i,
  input  logic                sec_valid_i,
  output logic                ser_o,
  input  logic                ser_i,
  output logic [SAMPLE_W-1:0] rx_pri_o,
  output logic                rx_pri_valid_o,
  output logic [SAMPLE_W-1:0] rx_sec_o,
  output logic                rx_sec_valid_o,
  output logic                rx_err_o,
  output logic                rx_align_lost_o
);
  logic clk_n;
  assign clk_n = ~clk_i;  // transmit side launches on the falling edge

  sfl_serializer #(.SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W), .FILL_W(FILL_W)) u_tx (
    .clk_i(clk_n), .rst_ni, .sync_i(sym_strobe_i),
    .pri_i(pri_sample_i), .pri_valid_i, .sec_i(sec_sample_i), .sec_valid_i,
    .ser_o
  );

  sfl_deserializer #(.SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W), .FILL_W(FILL_W)) u_rx (
    .clk_i, .rst_ni, .sync_i(sym_strobe_i), .ser_i,
    .pri_o(rx_pri_o), .pri_valid_o(rx_pri_valid_o),
    .sec_o(rx_sec_o), .sec_valid_o(rx_sec_valid_o),
    .err_o(rx_err_o), .lost_o(rx_align_lost_o)
  );
endmodule

// File: tb/dual_sample_frame_link_tb.sv
module dual_sample_frame_link_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [13:0] pri = '0, sec = '0;
  logic        pri_v = 1'b0, sec_v = 1'b0;
  logic        flip = 1'b0;
  logic        ser_o, ser_lb;
  logic [13:0] rx_pri, rx_sec;
  logic        rx_pri_v, rx_sec_v, rx_err, rx_lost;

  int checks = 0;
  int errors = 0;
  logic [13:0] hold_p = '0, hold_s = '0;
  logic        locked_m = 1'b0, lost_m = 1'b0;

  always #5 clk = ~clk;
  assign ser_lb = ser_o ^ flip;

  dual_sample_frame_link u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sym_strobe_i(strobe),
    .pri_sample_i(pri), .pri_valid_i(pri_v), .sec_sample_i(sec), .sec_valid_i(sec_v),
    .ser_o(ser_o), .ser_i(ser_lb),
    .rx_pri_o(rx_pri), .rx_pri_valid_o(rx_pri_v),
    .rx_sec_o(rx_sec), .rx_sec_valid_o(rx_sec_v),
    .rx_err_o(rx_err), .rx_align_lost_o(rx_lost)
  );

  function automatic logic [47:0] frame_bits(logic [13:0] p, logic [13:0] s);
    return {p, 2'b00, 8'hFF, s, 2'b00, 8'hFF};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Entered 3 time units after a rising edge. Runs slots 0..stop_k.
  task automatic frame(input logic [13:0] p, input logic pv, input logic [13:0] s, input logic sv,
                       input logic use_strobe, input int stop_k, input int mid_k,
                       input logic [13:0] mid_p, input int flip_k);
    logic [47:0] fb;
    logic [13:0] ep, es;
    ep = pv ? p : hold_p;
    es = sv ? s : hold_s;
    hold_p = ep;
    hold_s = es;
    fb = frame_bits(ep, es);
    strobe = use_strobe;
    pri = p; pri_v = pv; sec = s; sec_v = sv;
    if (use_strobe) begin
      locked_m = 1'b1;
      lost_m   = 1'b0;
    end else if (locked_m) lost_m = 1'b1;
    for (int k = 0; k <= stop_k; k++) begin
      @(posedge clk);
      #3;
      if (k == 0) begin
        strobe = 1'b0; pri_v = 1'b0; sec_v = 1'b0;
      end
      if (k == mid_k + 1) pri_v = 1'b0;
      if (k == flip_k) flip = 1'b0;
      // R1 R2 R3 R4: transmitted bit for slot k
      chk(ser_o === fb[47-k], $sformatf("R1/R3/R4 slot %0d", k), 32'(ser_o), 32'(fb[47-k]));
      chk(rx_pri_v === (locked_m && k == 15), "R5 pri valid", 32'(rx_pri_v), 32'(locked_m && k == 15));
      chk(rx_sec_v === (locked_m && k == 39), "R6 sec valid", 32'(rx_sec_v), 32'(locked_m && k == 39));
      if (locked_m && k == 15) chk(rx_pri === ep, "R5 pri data", 32'(rx_pri), 32'(ep));
      if (locked_m && k == 39) chk(rx_sec === es, "R6 sec data", 32'(rx_sec), 32'(es));
      chk(rx_err === (locked_m && k == flip_k), "R7 err", 32'(rx_err), 32'(locked_m && k == flip_k));
      chk(rx_lost === lost_m, "R8/R10 align lost", 32'(rx_lost), 32'(lost_m));
      if (k == mid_k) begin
        pri = mid_p; pri_v = 1'b1; hold_p = mid_p;
      end
      if (k + 1 == flip_k) flip = 1'b1;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #3;
    // R9: reset state
    chk(ser_o === 1'b1, "R9 ser_o", 32'(ser_o), 1);
    chk(rx_pri_v === 1'b0, "R9 pri valid", 32'(rx_pri_v), 0);
    chk(rx_sec_v === 1'b0, "R9 sec valid", 32'(rx_sec_v), 0);
    chk(rx_err === 1'b0, "R9 err", 32'(rx_err), 0);
    chk(rx_lost === 1'b0, "R9 lost", 32'(rx_lost), 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #3;
    // R1 R5 R6: full-scale corners
    frame(14'h1FFF, 1, 14'h2000, 1, 1, 47, -9, '0, -9);
    frame(14'h0000, 1, 14'h0ABC, 1, 1, 47, -9, '0, -9);
    // R3: mid-frame arrival deferred
    frame(14'h0123, 1, 14'h0456, 1, 1, 47, 20, 14'h0777, -9);
    frame(14'h3333, 0, 14'h3333, 0, 1, 47, -9, '0, -9);
    // R4 R8: free running, alignment lost
    frame(14'h0000, 0, 14'h0000, 0, 0, 47, -9, '0, -9);
    frame(14'h1555, 1, 14'h2AAA, 1, 0, 47, -9, '0, -9);
    frame(14'h0F0F, 1, 14'h30F0, 1, 1, 47, -9, '0, -9);
    // R7: corrupted pad and filler bits
    frame(14'h0042, 1, 14'h1001, 1, 1, 47, -9, '0, 14);
    frame(14'h2468, 1, 14'h1357, 1, 1, 47, -9, '0, 44);
    frame(14'h0001, 1, 14'h3FFF, 1, 1, 47, -9, '0, 20);
    // R10: strobe mid-frame
    frame(14'h0AAA, 1, 14'h0555, 1, 1, 20, -9, '0, -9);
    frame(14'h1234, 1, 14'h0321, 1, 1, 47, -9, '0, -9);
    frame(14'h0BBB, 1, 14'h0CCC, 1, 1, 30, -9, '0, -9);
    frame(14'h1ABC, 0, 14'h2DEF, 1, 1, 47, -9, '0, -9);
    // random frames
    for (int i = 0; i < 30; i++) begin
      logic [13:0] rp, rs;
      logic rpv, rsv;
      rp  = 14'($urandom);
      rs  = 14'($urandom);
      rpv = ($urandom % 4) != 0;
      rsv = ($urandom % 4) != 0;
      frame(rp, rpv, rs, rsv, 1, 47, -9, '0, -9);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule